// File: doc/BRIEF.md
# Transmit Carrier Sense Monitor

This block sits beside a frame transmitter and watches the carrier-sense line while the node is sending. Once the monitor is enabled, the node has to detect its own carrier at some point during the preamble. After that, the carrier has to stay up for the rest of the frame. Either failure causes the block to:

- issue a one-cycle abort request, which makes the transmitter cut the frame short;
- hold a CRC-inhibit level, so that no checksum is appended to the truncated frame;
- raise a sticky lost-carrier flag, which also tells the transmitter to switch itself off.

The transmitter supplies three phase strobes: frame start, preamble end and frame end. Carrier sense may come from another clock domain, so it passes through a parameterised synchroniser before any check uses it. Checking is gated by a monitor-enable input. Whatever drives that input should reset it low and keep it low when the media-independent interface is in use, because that interface does not loop the node's own carrier back.

Top module: `txcs_monitor`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `abort_o`, `crc_inhibit_o` and `lost_carr_o` are all 0.
- R2: When `mon_en` is 0, carrier sense has no effect: no abort is raised whatever `crs` does.
- R3: Synchronised carrier seen in any preamble cycle after the start cycle, up to and including the cycle of `tx_pre_end`, is latched and satisfies the preamble check.
- R4: With `mon_en` at 1 and no synchronised carrier seen during the preamble, `abort_o` is 1 in the cycle after the `tx_pre_end` cycle.
- R5: In the frame body, with `mon_en` at 1, a cycle whose synchronised carrier is 0 raises `abort_o` in the next cycle. A cycle that carries `tx_eof` is exempt from this check.
- R6: `abort_o` lasts one cycle. Once a frame has been aborted, no further abort is raised until the next `tx_sof`.
- R7: `crc_inhibit_o` goes to 1 together with `abort_o` and stays at 1 until the cycle after the next `tx_sof`.
- R8: `lost_carr_o` goes to 1 together with `abort_o` and stays at 1 until the cycle after a `tx_restart` pulse. An abort in the same cycle as a restart wins.
- R9: `crs` passes through `SYNC_STAGES` flip-flops. A carrier drop driven in cycle k is acted on in cycle k+`SYNC_STAGES`, and the abort shows one cycle after that.
- R10: The preamble carrier latch is cleared by `tx_sof`, so carrier seen in an earlier frame never satisfies a later frame's check.
- R11: A `tx_eof` that arrives during the preamble ends the frame without any check and without an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitor enable; 1 turns on carrier checking |
| crs | input | 1 | Raw carrier sense from the line side |
| tx_sof | input | 1 | One-cycle strobe: a frame starts (preamble begins) |
| tx_pre_end | input | 1 | One-cycle strobe: last preamble cycle |
| tx_eof | input | 1 | One-cycle strobe: frame ends |
| tx_restart | input | 1 | One-cycle strobe: transmitter enabled again, clears the flag |
| abort_o | output | 1 | One-cycle abort request to the transmitter |
| crc_inhibit_o | output | 1 | 1 while the current frame must end without CRC |
| lost_carr_o | output | 1 | Sticky lost-carrier status; transmitter stays off while 1 |

## Verification
The bench builds the monitor with `SYNC_STAGES` = 2. This default makes the synchroniser delay visible, so the bench can check that a carrier pulse seen late in the preamble still counts once it has crossed the chain, and that a carrier which comes back after an abort does not cancel it. Because the delay is two cycles, carrier from a previous frame is still in flight when the next frame starts. The bench uses this to probe how the latch is cleared at frame start. Short preambles of one cycle and frames cut short during the preamble are part of the random mix.

// File: rtl/txcs_pkg.sv
package txcs_pkg;

    // Transmit phase as seen by the monitor.
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_PREAMBLE = 2'd1,
        PH_BODY     = 2'd2,
        PH_HALTED   = 2'd3
    } tx_phase_e;

    // Phase strobes from the transmitter, bundled.
    typedef struct packed {
        logic sof;
        logic pre_end;
        logic eof;
    } phase_strobes_t;

    // Status bundle driven by the flag stage.
    typedef struct packed {
        logic abort;
        logic crc_inhibit;
        logic lost_carr;
    } mon_status_t;

    // Preamble-end check: carrier must have been latched or be present now.
    function automatic logic preamble_fault(input logic mon, input logic seen, input logic cs);
        return mon && !(seen || cs);
    endfunction

    // Body check: carrier must stay present.
    function automatic logic body_fault(input logic mon, input logic cs);
        return mon && !cs;
    endfunction

endpackage

// File: rtl/txcs_crs_sync.sv
module txcs_crs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic crs_i,
    output logic crs_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign crs_o = crs_i;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q[0] <= 1'b0;
                else     q[0] <= crs_i;
            end
            for (genvar i = 1; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) q[i] <= 1'b0;
                    else     q[i] <= q[i-1];
                end
            end
            assign crs_o = q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/txcs_phase_fsm.sv
module txcs_phase_fsm
    import txcs_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  phase_strobes_t strb_i,
    input  logic           mon_en_i,
    input  logic           crs_s_i,
    output logic           fault_o,
    output tx_phase_e      phase_o
);

    tx_phase_e phase_q, phase_d;
    logic      seen_q, seen_d;
    logic      fault_d;

    always_comb begin
        phase_d = phase_q;
        seen_d  = seen_q;
        fault_d = 1'b0;
        if (strb_i.sof) begin
            phase_d = PH_PREAMBLE;
            seen_d  = 1'b0;
        end else begin
            unique case (phase_q)
                PH_PREAMBLE: begin
                    if (strb_i.eof) begin
                        phase_d = PH_IDLE;
                    end else if (strb_i.pre_end) begin
                        if (preamble_fault(mon_en_i, seen_q, crs_s_i)) begin
                            fault_d = 1'b1;
                            phase_d = PH_HALTED;
                        end else begin
                            phase_d = PH_BODY;
                        end
                    end else begin
                        seen_d = seen_q | crs_s_i;
                    end
                end
                PH_BODY: begin
                    if (strb_i.eof) begin
                        phase_d = PH_IDLE;
                    end else if (body_fault(mon_en_i, crs_s_i)) begin
                        fault_d = 1'b1;
                        phase_d = PH_HALTED;
                    end
                end
                PH_HALTED: begin
                    if (strb_i.eof) phase_d = PH_IDLE;
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            seen_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            seen_q  <= seen_d;
        end
    end

    assign fault_o = fault_d;
    assign phase_o = phase_q;

endmodule

// File: rtl/txcs_status.sv
module txcs_status
    import txcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fault_i,
    input  logic        sof_i,
    input  logic        restart_i,
    output mon_status_t stat_o
);

    mon_status_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.abort <= fault_i;
            if (fault_i)    stat_q.crc_inhibit <= 1'b1;
            else if (sof_i) stat_q.crc_inhibit <= 1'b0;
            if (fault_i)        stat_q.lost_carr <= 1'b1;
            else if (restart_i) stat_q.lost_carr <= 1'b0;
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/txcs_monitor.sv
module txcs_monitor
    import txcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mon_en,
    input  logic crs,
    input  logic tx_sof,
    input  logic tx_pre_end,
    input  logic tx_eof,
    input  logic tx_restart,
    output logic abort_o,
    output logic crc_inhibit_o,
    output logic lost_carr_o
);

    logic           crs_s;
    logic           fault;
    tx_phase_e      phase;
    phase_strobes_t strb;
    mon_status_t    stat;

    assign strb = '{sof: tx_sof, pre_end: tx_pre_end, eof: tx_eof};

    txcs_crs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .crs_i (crs),
        .crs_o (crs_s)
    );

    txcs_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .strb_i   (strb),
        .mon_en_i (mon_en),
        .crs_s_i  (crs_s),
        .fault_o  (fault),
        .phase_o  (phase)
    );

    txcs_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .fault_i   (fault),
        .sof_i     (tx_sof),
        .restart_i (tx_restart),
        .stat_o    (stat)
    );

    assign abort_o       = stat.abort;
    assign crc_inhibit_o = stat.crc_inhibit;
    assign lost_carr_o   = stat.lost_carr;

endmodule

// File: rtl/txcs_monitor_chk.sv
module txcs_monitor_chk (
    input logic clk,
    input logic rst,
    input logic mon_en,
    input logic tx_sof,
    input logic tx_restart,
    input logic abort_o,
    input logic crc_inhibit_o,
    input logic lost_carr_o
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!abort_o && !crc_inhibit_o && !lost_carr_o)); // R1

    AST_ABORT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> $past(mon_en)); // R2

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o); // R6

    AST_ABORT_INHIBITS: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> crc_inhibit_o); // R7

    AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (crc_inhibit_o && !tx_sof) |=> crc_inhibit_o); // R7

    AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> lost_carr_o); // R8

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (lost_carr_o && !tx_restart) |=> lost_carr_o); // R8

endmodule

bind txcs_monitor txcs_monitor_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mon_en        (mon_en),
    .tx_sof        (tx_sof),
    .tx_restart    (tx_restart),
    .abort_o       (abort_o),
    .crc_inhibit_o (crc_inhibit_o),
    .lost_carr_o   (lost_carr_o)
);

// File: tb/tb_txcs_monitor.sv
`timescale 1ns/1ps
module tb_txcs_monitor;

    localparam int STG = 2;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst, mon_en, crs, tx_sof, tx_pre_end, tx_eof, tx_restart;
    logic abort_o, crc_inhibit_o, lost_carr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    txcs_monitor #(.SYNC_STAGES(STG)) dut (
        .clk(clk), .rst(rst), .mon_en(mon_en), .crs(crs),
        .tx_sof(tx_sof), .tx_pre_end(tx_pre_end), .tx_eof(tx_eof),
        .tx_restart(tx_restart), .abort_o(abort_o),
        .crc_inhibit_o(crc_inhibit_o), .lost_carr_o(lost_carr_o)
    );

    // Reference model state, built from the requirements.
    int   m_phase;        // 0 idle, 1 preamble, 2 body, 3 halted
    logic m_seen;
    logic e_abort, e_inh, e_lost;
    logic hist [0:STG];

    task automatic model_reset();
        m_phase = 0; m_seen = 1'b0;
        e_abort = 1'b0; e_inh = 1'b0; e_lost = 1'b0;
        for (int i = 0; i <= STG; i++) hist[i] = 1'b0;
    endtask

    function automatic logic pre_fault(input logic en, input logic seen, input logic cs);
        return en && !seen && !cs;
    endfunction

    task automatic model_step(input logic sof, input logic pe, input logic eof,
                              input logic cs, input logic en, input logic rs);
        logic cs_s;
        logic flt;
        for (int i = STG; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = cs;
        cs_s = hist[STG];
        flt = 1'b0;
        if (sof) begin
            m_phase = 1; m_seen = 1'b0;
        end else begin
            case (m_phase)
                1: if (eof) m_phase = 0;
                   else if (pe) begin
                       if (pre_fault(en, m_seen, cs_s)) begin flt = 1'b1; m_phase = 3; end
                       else m_phase = 2;
                   end else m_seen = m_seen | cs_s;
                2: if (eof) m_phase = 0;
                   else if (en && !cs_s) begin flt = 1'b1; m_phase = 3; end
                3: if (eof) m_phase = 0;
                default: ;
            endcase
        end
        e_abort = flt;
        if (flt) e_inh = 1'b1; else if (sof) e_inh = 1'b0;
        if (flt) e_lost = 1'b1; else if (rs) e_lost = 1'b0;
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock cycle: drive at negedge, compare just after posedge.
    task automatic cyc(input string tag, input logic sof, input logic pe, input logic eof,
                       input logic cs, input logic en, input logic rs);
        @(negedge clk);
        tx_sof = sof; tx_pre_end = pe; tx_eof = eof; crs = cs; mon_en = en; tx_restart = rs;
        model_step(sof, pe, eof, cs, en, rs);
        @(posedge clk);
        #1;
        chk(tag, "abort_o", abort_o, e_abort);
        chk(tag, "crc_inhibit_o", crc_inhibit_o, e_inh);
        chk(tag, "lost_carr_o", lost_carr_o, e_lost);
    endtask

    task automatic idle(input string tag, input int n, input logic cs, input logic en);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, cs, en, 0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired checks=%0d", checks);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; mon_en = 0; crs = 0; tx_sof = 0; tx_pre_end = 0; tx_eof = 0; tx_restart = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "abort_o in reset", abort_o, 1'b0);
        chk("R1", "crc_inhibit_o in reset", crc_inhibit_o, 1'b0);
        chk("R1", "lost_carr_o in reset", lost_carr_o, 1'b0);
        @(negedge clk); rst = 1'b0;
        idle("R1", 3, 0, 1);

        // R4: no carrier in the preamble, abort right after the preamble end
        cyc("R4", 1, 0, 0, 0, 1, 0);
        idle("R4", 3, 0, 1);
        cyc("R4", 0, 1, 0, 0, 1, 0);
        chk("R4", "abort after preamble end", abort_o, 1'b1);
        chk("R8", "lost flag with abort", lost_carr_o, 1'b1);
        chk("R7", "crc inhibit with abort", crc_inhibit_o, 1'b1);
        // R6: body without carrier after an abort: no second abort
        cyc("R6", 0, 0, 0, 0, 1, 0);
        chk("R6", "abort single cycle", abort_o, 1'b0);
        idle("R6", 5, 0, 1);
        cyc("R6", 0, 0, 1, 0, 1, 0);
        // R8: restart clears the flag; R7: inhibit stays until next start
        cyc("R8", 0, 0, 0, 0, 1, 1);
        chk("R8", "lost cleared by restart", lost_carr_o, 1'b0);
        chk("R7", "inhibit held past restart", crc_inhibit_o, 1'b1);
        cyc("R7", 1, 0, 0, 1, 1, 0);
        chk("R7", "inhibit cleared by frame start", crc_inhibit_o, 1'b0);
        idle("R7", 3, 1, 1);
        cyc("R7", 0, 1, 0, 1, 1, 0);
        idle("R7", 3, 1, 1);
        cyc("R7", 0, 0, 1, 1, 1, 0);

        // R2: monitor disabled, no carrier at all
        cyc("R2", 1, 0, 0, 0, 0, 0);
        idle("R2", 3, 0, 0);
        cyc("R2", 0, 1, 0, 0, 0, 0);
        chk("R2", "no abort when disabled", abort_o, 1'b0);
        idle("R2", 6, 0, 0);
        cyc("R2", 0, 0, 1, 0, 0, 0);
        chk("R2", "flag untouched when disabled", lost_carr_o, 1'b0);

        // R3: one-cycle carrier early in the preamble is latched
        idle("R3", 3, 0, 1);
        cyc("R3", 1, 0, 0, 0, 1, 0);
        cyc("R3", 0, 0, 0, 1, 1, 0);
        idle("R3", 4, 0, 1);
        cyc("R3", 0, 1, 0, 1, 1, 0);
        chk("R3", "latched carrier passes preamble check", abort_o, 1'b0);
        idle("R3", 4, 1, 1);
        cyc("R3", 0, 0, 1, 1, 1, 0);

        // R5/R9: single-cycle drop in the body, abort after STG+1 edges
        cyc("R5", 1, 0, 0, 1, 1, 0);
        idle("R5", 3, 1, 1);
        cyc("R5", 0, 1, 0, 1, 1, 0);
        idle("R5", 3, 1, 1);
        cyc("R9", 0, 0, 0, 0, 1, 0);
        chk("R9", "no abort at drop cycle", abort_o, 1'b0);
        cyc("R9", 0, 0, 0, 1, 1, 0);
        chk("R9", "no abort one cycle after drop", abort_o, 1'b0);
        cyc("R9", 0, 0, 0, 1, 1, 0);
        chk("R9", "abort after sync delay", abort_o, 1'b1);
        cyc("R5", 0, 0, 1, 1, 1, 1);
        chk("R8", "abort wins over nothing; restart clears", lost_carr_o, 1'b0);

        // R5: drop reaching the check exactly on the end-of-frame cycle is exempt
        cyc("R5", 1, 0, 0, 1, 1, 0);
        idle("R5", 2, 1, 1);
        cyc("R5", 0, 1, 0, 1, 1, 0);
        idle("R5", 2, 1, 1);
        cyc("R5", 0, 0, 0, 0, 1, 0);
        cyc("R5", 0, 0, 0, 0, 1, 0);
        cyc("R5", 0, 0, 1, 0, 1, 0);
        chk("R5", "end-of-frame cycle exempt", abort_o, 1'b0);
        idle("R5", 3, 0, 1);
        chk("R5", "idle carrier loss ignored", abort_o, 1'b0);

        // R11 then R10: short frame with carrier, then a frame without carrier
        cyc("R11", 1, 0, 0, 1, 1, 0);
        idle("R11", 4, 1, 1);
        cyc("R11", 0, 0, 1, 0, 1, 0);
        chk("R11", "end during preamble, no abort", abort_o, 1'b0);
        idle("R10", 4, 0, 1);
        cyc("R10", 1, 0, 0, 0, 1, 0);
        idle("R10", 3, 0, 1);
        cyc("R10", 0, 1, 0, 0, 1, 0);
        chk("R10", "old carrier not counted", abort_o, 1'b1);
        cyc("R10", 0, 0, 1, 0, 1, 0);

        // R8: abort and restart in the same cycle, abort wins
        cyc("R8", 1, 0, 0, 0, 1, 0);
        cyc("R8", 0, 1, 0, 0, 1, 1);
        chk("R8", "abort beats restart", lost_carr_o, 1'b1);
        cyc("R8", 0, 0, 1, 0, 1, 1);
        chk("R8", "restart later clears", lost_carr_o, 1'b0);

        // Random frames compared against the model every cycle
        for (int f = 0; f < 400; f++) begin
            logic en;
            int   mode;
            int   plen;
            int   blen;
            bit   cut;
            en   = ($urandom % 4) != 0;
            mode = $urandom % 4;
            plen = 1 + ($urandom % 8);
            blen = 1 + ($urandom % 16);
            cut  = ($urandom % 10) == 0;
            for (int g = 0; g < int'($urandom % 4); g++)
                cyc("R5", 0, 0, 0, logic'($urandom % 2), en, logic'(($urandom % 10) == 0));
            cyc("R3", 1, 0, 0, mode != 1, en, 0);
            for (int p = 0; p < plen; p++) begin
                logic c;
                c = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 :
                    (mode == 2) ? logic'(($urandom % 8) != 0) : logic'(p >= plen / 2);
                cyc("R4", 0, 0, 0, c, en, logic'(($urandom % 10) == 0));
            end
            if (cut) begin
                cyc("R11", 0, 0, 1, mode != 1, en, 0);
            end else begin
                cyc("R4", 0, 1, 0, mode != 1, en, 0);
                for (int b = 0; b < blen; b++) begin
                    logic c;
                    c = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 :
                        (mode == 2) ? logic'(($urandom % 12) != 0) : logic'(b < blen / 2);
                    cyc("R5", 0, 0, 0, c, en, logic'(($urandom % 10) == 0));
                end
                cyc("R6", 0, 0, 1, logic'($urandom % 2), en, 0);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule